// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This unit sits on a 16-bit I/O port bus and implements the legacy two-register scheme for reaching PCI configuration space. A 32-bit selector register at port 0xCF8 holds an enable bit and a target address. While the enable bit is set, the four data ports 0xCFC to 0xCFF act as a window. Each access through that window is turned into a configuration request with the bus, device, function, dword register and byte offset on separate fields. All other I/O traffic, and the window ports while the enable bit is clear, is passed through unchanged to an ordinary I/O target.

The unit handles one request at a time. An I/O request is accepted only while the unit is idle. Forwarded requests wait for their downstream response through valid/ready handshakes, and the I/O response is then returned as a single-cycle pulse. When a write to the selector flips the enable bit, a one-cycle pulse tells upstream decode logic that the set of claimed ports has changed.

Top module: `pcicfg_port_decoder`

## Requirements
- R1: After reset the selector register reads as zero, so the data window is closed and 0xCFC to 0xCFF go to the I/O target.
- R2: A write of size 4 to port 0xCF8 stores all 32 bits. A read of size 4 from 0xCF8 returns the full stored value, including bit 31. Sizes are encoded as a byte count (1, 2 or 4).
- R3: While bit 31 of the selector is 0, any access to 0xCFC to 0xCFF is forwarded to the I/O target with its port, size, direction and write data unchanged, and no configuration request is issued.
- R4: While bit 31 is 1, an access to port 0xCFC+k issues one configuration request with bus = selector[23:16], device = selector[15:11], function = selector[10:8], register = selector[7:2] and byte offset = k. Size, direction and write data are kept, and the read data of the configuration response is returned on the I/O response. Selector bits 30:24 and 1:0 take no part in the request.
- R5: An access to port 0xCF8 with a size other than 4 is forwarded as ordinary I/O and leaves the selector unchanged.
- R6: Accesses of any size to ports 0xCF9, 0xCFA and 0xCFB are answered locally. Reads return 0xFFFFFFFF. Writes are acknowledged, change nothing and issue no downstream request.
- R7: A configuration request stays valid, with all fields stable, until it is accepted. The I/O response follows the configuration response. No more than one of the I/O-ready, configuration-request, I/O-target-request and I/O-response signals is high at a time.
- R8: `range_changed` pulses for exactly one cycle, together with the I/O response, when a selector write changes bit 31. It stays low for selector writes that keep bit 31.
- R9: Ports outside 0xCF8 to 0xCFF are forwarded to the I/O target unchanged, over the whole 16-bit space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | I/O request present |
| io_req_ready | output | 1 | Unit idle, request accepted this cycle |
| io_req_port | input | 16 | I/O port address |
| io_req_size | input | 3 | Access size in bytes (1, 2, 4) |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_wdata | input | 32 | Write data |
| io_rsp_valid | output | 1 | One-cycle response pulse |
| io_rsp_rdata | output | 32 | Read data of the response |
| range_changed | output | 1 | One-cycle pulse: window opened or closed |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration target accepts request |
| cfg_req_bus | output | 8 | Bus number |
| cfg_req_dev | output | 5 | Device number |
| cfg_req_func | output | 3 | Function number |
| cfg_req_dword | output | 6 | Dword register index |
| cfg_req_byte | output | 2 | Byte offset within the dword |
| cfg_req_size | output | 3 | Access size in bytes |
| cfg_req_write | output | 1 | 1 = write |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Configuration response valid |
| cfg_rsp_rdata | input | 32 | Configuration read data |
| pio_req_valid | output | 1 | Pass-through I/O request valid |
| pio_req_ready | input | 1 | I/O target accepts request |
| pio_req_port | output | 16 | Forwarded port address |
| pio_req_size | output | 3 | Forwarded size |
| pio_req_write | output | 1 | Forwarded direction |
| pio_req_wdata | output | 32 | Forwarded write data |
| pio_rsp_valid | input | 1 | I/O target response valid |
| pio_rsp_rdata | input | 32 | I/O target read data |

## Verification
The bench goes after the port boundaries. A decoder that compared full ports instead of masked ones would send 0xCFD to 0xCFF elsewhere. One that ignored size would treat a 2-byte write at 0xCF8 as a selector update and corrupt it. One that let 0xCF9 to 0xCFB fall through would leak writes downstream or return target data instead of all-ones. With the window open, all four byte offsets are swept using a selector whose bits 30:24 and 1:0 are set. This exposes a design that copies selector bits into the byte offset or leaks high bits into the bus number. The bench also stalls the configuration target's ready signal to catch requests that drop or change while waiting. It writes the selector with and without flipping bit 31, so both a missing and a spurious `range_changed` pulse are caught.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int PORT_W = 16;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 3;

    // how an incoming I/O access is handled
    typedef enum logic [1:0] {
        ACC_SEL  = 2'd0,   // selector register access
        ACC_HOLE = 2'd1,   // claimed but unmapped: all-ones / drop
        ACC_CFG  = 2'd2,   // open window: configuration request
        ACC_PIO  = 2'd3    // plain pass-through
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CFG_REQ  = 3'd1,
        ST_CFG_WAIT = 3'd2,
        ST_PIO_REQ  = 3'd3,
        ST_PIO_WAIT = 3'd4,
        ST_RESP     = 3'd5
    } seq_state_e;

endpackage

// File: rtl/pcicfg_classify.sv
module pcicfg_classify
    import pcicfg_pkg::*;
#(
    parameter logic [PORT_W-1:0] SEL_PORT  = 16'hCF8,
    parameter logic [PORT_W-1:0] WIN_PORT  = 16'hCFC,
    parameter int                SEL_BYTES = 4
) (
    input  logic [PORT_W-1:0] port,
    input  logic [SIZE_W-1:0] size,
    input  logic              win_open,
    output acc_kind_e         kind
);
    localparam int GRAN_W = 2;

    logic sel_group;
    logic win_group;
    logic sel_exact;

    always_comb begin
        sel_group = (port[PORT_W-1:GRAN_W] == SEL_PORT[PORT_W-1:GRAN_W]);
        win_group = (port[PORT_W-1:GRAN_W] == WIN_PORT[PORT_W-1:GRAN_W]);
        sel_exact = (port == SEL_PORT);
        if (sel_exact && (size == SEL_BYTES[SIZE_W-1:0])) begin
            kind = ACC_SEL;
        end else if (sel_group && !sel_exact) begin
            kind = ACC_HOLE;
        end else if (win_group && win_open) begin
            kind = ACC_CFG;
        end else begin
            kind = ACC_PIO;
        end
    end

endmodule

// File: rtl/pcicfg_sel_reg.sv
module pcicfg_sel_reg
    import pcicfg_pkg::*;
#(
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sel_q,
    output logic              chg_q
);
    typedef struct packed {
        logic [DATA_W-1:0] sel;
        logic              chg;
    } sel_regs_t;

    sel_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.chg = 1'b0;
        if (wr_en) begin
            r_d.sel = wr_data;
            r_d.chg = (wr_data[EN_BIT] != r_q.sel[EN_BIT]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_q = r_q.sel;
    assign chg_q = r_q.chg;

    AST_CHG_MEANS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> (sel_q[EN_BIT] != $past(sel_q[EN_BIT]))); // R8
    AST_FLIP_MEANS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[EN_BIT] != $past(sel_q[EN_BIT])) |-> chg_q); // R8
    AST_CHG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |=> !chg_q); // R8

endmodule

// File: rtl/pcicfg_seq.sv
module pcicfg_seq
    import pcicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req_valid,
    input  logic [PORT_W-1:0] io_req_port,
    input  logic [SIZE_W-1:0] io_req_size,
    input  logic              io_req_write,
    input  logic [DATA_W-1:0] io_req_wdata,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] sel_value,
    input  logic              cfg_req_ready,
    input  logic              cfg_rsp_valid,
    input  logic [DATA_W-1:0] cfg_rsp_rdata,
    input  logic              pio_req_ready,
    input  logic              pio_rsp_valid,
    input  logic [DATA_W-1:0] pio_rsp_rdata,
    output logic              sel_wr,
    output logic              idle,
    output logic              rsp_valid,
    output logic              cfg_valid,
    output logic              pio_valid,
    output logic [PORT_W-1:0] held_port,
    output logic [SIZE_W-1:0] held_size,
    output logic              held_write,
    output logic [DATA_W-1:0] held_wdata,
    output logic [DATA_W-1:0] held_rdata
);
    typedef struct packed {
        seq_state_e        st;
        logic [PORT_W-1:0] port;
        logic [SIZE_W-1:0] size;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        sel_wr = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (io_req_valid) begin
                    s_d.port  = io_req_port;
                    s_d.size  = io_req_size;
                    s_d.wr    = io_req_write;
                    s_d.wdata = io_req_wdata;
                    unique case (kind)
                        ACC_SEL: begin
                            sel_wr    = io_req_write;
                            s_d.rdata = sel_value;
                            s_d.st    = ST_RESP;
                        end
                        ACC_HOLE: begin
                            s_d.rdata = '1;
                            s_d.st    = ST_RESP;
                        end
                        ACC_CFG: s_d.st = ST_CFG_REQ;
                        default: s_d.st = ST_PIO_REQ;
                    endcase
                end
            end
            ST_CFG_REQ:  if (cfg_req_ready) s_d.st = ST_CFG_WAIT;
            ST_CFG_WAIT: begin
                if (cfg_rsp_valid) begin
                    s_d.rdata = cfg_rsp_rdata;
                    s_d.st    = ST_RESP;
                end
            end
            ST_PIO_REQ:  if (pio_req_ready) s_d.st = ST_PIO_WAIT;
            ST_PIO_WAIT: begin
                if (pio_rsp_valid) begin
                    s_d.rdata = pio_rsp_rdata;
                    s_d.st    = ST_RESP;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle       = (s_q.st == ST_IDLE);
    assign rsp_valid  = (s_q.st == ST_RESP);
    assign cfg_valid  = (s_q.st == ST_CFG_REQ);
    assign pio_valid  = (s_q.st == ST_PIO_REQ);
    assign held_port  = s_q.port;
    assign held_size  = s_q.size;
    assign held_write = s_q.wr;
    assign held_wdata = s_q.wdata;
    assign held_rdata = s_q.rdata;

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_CFG_WAITS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CFG_WAIT && !cfg_rsp_valid) |=> !rsp_valid); // R7

endmodule

// File: rtl/pcicfg_port_decoder.sv
module pcicfg_port_decoder
    import pcicfg_pkg::*;
#(
    parameter logic [PORT_W-1:0] SEL_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] WIN_PORT = 16'hCFC,
    parameter int                EN_BIT   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req_valid,
    output logic              io_req_ready,
    input  logic [15:0]       io_req_port,
    input  logic [2:0]        io_req_size,
    input  logic              io_req_write,
    input  logic [31:0]       io_req_wdata,
    output logic              io_rsp_valid,
    output logic [31:0]       io_rsp_rdata,
    output logic              range_changed,
    output logic              cfg_req_valid,
    input  logic              cfg_req_ready,
    output logic [7:0]        cfg_req_bus,
    output logic [4:0]        cfg_req_dev,
    output logic [2:0]        cfg_req_func,
    output logic [5:0]        cfg_req_dword,
    output logic [1:0]        cfg_req_byte,
    output logic [2:0]        cfg_req_size,
    output logic              cfg_req_write,
    output logic [31:0]       cfg_req_wdata,
    input  logic              cfg_rsp_valid,
    input  logic [31:0]       cfg_rsp_rdata,
    output logic              pio_req_valid,
    input  logic              pio_req_ready,
    output logic [15:0]       pio_req_port,
    output logic [2:0]        pio_req_size,
    output logic              pio_req_write,
    output logic [31:0]       pio_req_wdata,
    input  logic              pio_rsp_valid,
    input  logic [31:0]       pio_rsp_rdata
);
    // field layout of the selector register
    localparam int BUS_LO = 16;
    localparam int BUS_W  = 8;
    localparam int DEV_LO = 11;
    localparam int DEV_W  = 5;
    localparam int FN_LO  = 8;
    localparam int FN_W   = 3;
    localparam int DW_LO  = 2;
    localparam int DW_W   = 6;
    localparam int BYTE_W = DW_LO;

    acc_kind_e         kind;
    logic [DATA_W-1:0] sel_value;
    logic              sel_wr;
    logic              sel_chg;
    logic [PORT_W-1:0] held_port;
    logic [SIZE_W-1:0] held_size;
    logic              held_write;
    logic [DATA_W-1:0] held_wdata;
    logic              seq_idle;

    pcicfg_classify #(
        .SEL_PORT (SEL_PORT),
        .WIN_PORT (WIN_PORT),
        .SEL_BYTES(DATA_W / 8)
    ) u_classify (
        .port    (io_req_port),
        .size    (io_req_size),
        .win_open(sel_value[EN_BIT]),
        .kind    (kind)
    );

    pcicfg_sel_reg #(
        .EN_BIT(EN_BIT)
    ) u_sel_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel_wr),
        .wr_data(io_req_wdata),
        .sel_q  (sel_value),
        .chg_q  (sel_chg)
    );

    pcicfg_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_req_valid (io_req_valid),
        .io_req_port  (io_req_port),
        .io_req_size  (io_req_size),
        .io_req_write (io_req_write),
        .io_req_wdata (io_req_wdata),
        .kind         (kind),
        .sel_value    (sel_value),
        .cfg_req_ready(cfg_req_ready),
        .cfg_rsp_valid(cfg_rsp_valid),
        .cfg_rsp_rdata(cfg_rsp_rdata),
        .pio_req_ready(pio_req_ready),
        .pio_rsp_valid(pio_rsp_valid),
        .pio_rsp_rdata(pio_rsp_rdata),
        .sel_wr       (sel_wr),
        .idle         (seq_idle),
        .rsp_valid    (io_rsp_valid),
        .cfg_valid    (cfg_req_valid),
        .pio_valid    (pio_req_valid),
        .held_port    (held_port),
        .held_size    (held_size),
        .held_write   (held_write),
        .held_wdata   (held_wdata),
        .held_rdata   (io_rsp_rdata)
    );

    assign io_req_ready  = seq_idle;
    assign range_changed = sel_chg;

    // configuration request: selector fields plus the low bits of the data port
    assign cfg_req_bus   = sel_value[BUS_LO +: BUS_W];
    assign cfg_req_dev   = sel_value[DEV_LO +: DEV_W];
    assign cfg_req_func  = sel_value[FN_LO  +: FN_W];
    assign cfg_req_dword = sel_value[DW_LO  +: DW_W];
    assign cfg_req_byte  = held_port[BYTE_W-1:0];
    assign cfg_req_size  = held_size;
    assign cfg_req_write = held_write;
    assign cfg_req_wdata = held_wdata;

    assign pio_req_port  = held_port;
    assign pio_req_size  = held_size;
    assign pio_req_write = held_write;
    assign pio_req_wdata = held_wdata;

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_req_ready, cfg_req_valid, pio_req_valid, io_rsp_valid})); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && !cfg_req_ready) |=> (cfg_req_valid && $stable(cfg_req_bus)
        && $stable(cfg_req_dev) && $stable(cfg_req_func) && $stable(cfg_req_dword)
        && $stable(cfg_req_byte) && $stable(cfg_req_wdata))); // R7
    AST_CFG_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> sel_value[EN_BIT]); // R3
    AST_CHG_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        range_changed |-> io_rsp_valid); // R8

endmodule

// File: tb/pcicfg_port_decoder_bench.sv
module pcicfg_port_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req_valid = 1'b0;
    logic        io_req_ready;
    logic [15:0] io_req_port = '0;
    logic [2:0]  io_req_size = '0;
    logic        io_req_write = 1'b0;
    logic [31:0] io_req_wdata = '0;
    logic        io_rsp_valid;
    logic [31:0] io_rsp_rdata;
    logic        range_changed;
    logic        cfg_req_valid;
    logic        cfg_req_ready = 1'b0;
    logic [7:0]  cfg_req_bus;
    logic [4:0]  cfg_req_dev;
    logic [2:0]  cfg_req_func;
    logic [5:0]  cfg_req_dword;
    logic [1:0]  cfg_req_byte;
    logic [2:0]  cfg_req_size;
    logic        cfg_req_write;
    logic [31:0] cfg_req_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_rdata = '0;
    logic        pio_req_valid;
    logic        pio_req_ready = 1'b0;
    logic [15:0] pio_req_port;
    logic [2:0]  pio_req_size;
    logic        pio_req_write;
    logic [31:0] pio_req_wdata;
    logic        pio_rsp_valid = 1'b0;
    logic [31:0] pio_rsp_rdata = '0;

    always #10 clk = ~clk;

    pcicfg_port_decoder u_pcicfg_port_decoder (.*);

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // downstream target capture
    int          n_cfg = 0;
    int          n_pio = 0;
    int          stall_cyc = 0;
    bit          stall_bad = 1'b0;
    bit          cfg_rsp_sent = 1'b0;
    logic [31:0] cap_cfg_addr;
    logic [2:0]  cap_cfg_size;
    logic        cap_cfg_wr;
    logic [31:0] cap_cfg_wdata;
    logic [15:0] cap_pio_port;
    logic [2:0]  cap_pio_size;
    logic        cap_pio_wr;
    logic [31:0] cap_pio_wdata;

    // transaction results
    logic [31:0] rd;
    logic        chg_seen;

    function automatic logic [31:0] cfg_model(logic [31:0] a);
        return {a[31:8], 8'hC3} ^ 32'h0F0F_0000;
    endfunction

    function automatic logic [31:0] pio_model(logic [15:0] p);
        return {~p, p};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // configuration target, with an optional ready stall
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_req_valid && !cfg_req_ready) begin
                n_cfg++;
                cap_cfg_addr  = {cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_dword,
                                 cfg_req_byte, 8'h00};
                cap_cfg_size  = cfg_req_size;
                cap_cfg_wr    = cfg_req_write;
                cap_cfg_wdata = cfg_req_wdata;
                for (int i = 0; i < stall_cyc; i++) begin
                    @(negedge clk);
                    if (!cfg_req_valid || cfg_req_wdata !== cap_cfg_wdata ||
                        {cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_dword,
                         cfg_req_byte, 8'h00} !== cap_cfg_addr)
                        stall_bad = 1'b1;
                end
                cfg_req_ready = 1'b1;
                @(negedge clk);
                cfg_req_ready = 1'b0;
                @(negedge clk);
                cfg_rsp_valid = 1'b1;
                cfg_rsp_rdata = cfg_model(cap_cfg_addr);
                cfg_rsp_sent  = 1'b1;
                @(negedge clk);
                cfg_rsp_valid = 1'b0;
            end
        end
    end

    // plain I/O target
    initial begin
        forever begin
            @(negedge clk);
            if (pio_req_valid && !pio_req_ready) begin
                n_pio++;
                cap_pio_port  = pio_req_port;
                cap_pio_size  = pio_req_size;
                cap_pio_wr    = pio_req_write;
                cap_pio_wdata = pio_req_wdata;
                pio_req_ready = 1'b1;
                @(negedge clk);
                pio_req_ready = 1'b0;
                @(negedge clk);
                pio_rsp_valid = 1'b1;
                pio_rsp_rdata = pio_model(cap_pio_port);
                @(negedge clk);
                pio_rsp_valid = 1'b0;
            end
        end
    end

    task automatic io_xfer(logic [15:0] p, logic [2:0] sz, logic wr, logic [31:0] wd);
        bit got = 1'b0;
        @(negedge clk);
        io_req_valid = 1'b1;
        io_req_port  = p;
        io_req_size  = sz;
        io_req_write = wr;
        io_req_wdata = wd;
        for (int i = 0; i < 50 && !io_req_ready; i++) @(negedge clk);
        @(negedge clk);
        io_req_valid = 1'b0;
        for (int i = 0; i < 100 && !got; i++) begin
            if (io_rsp_valid) begin
                got      = 1'b1;
                rd       = io_rsp_rdata;
                chg_seen = range_changed;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) begin
            total++;
            bad++;
            $display("FAIL R7 no response act=0 exp=1 port=%h", p);
            rd = 'x;
            chg_seen = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        int np;
        chk("R1 ready after reset", {31'd0, io_req_ready}, 32'd1);
        chk("R1 no range pulse", {31'd0, range_changed}, 32'd0);
        io_xfer(16'hCF8, 3'd4, 1'b0, '0);
        chk("R1 selector reset value", rd, 32'h0);
        np = n_pio;
        io_xfer(16'hCFC, 3'd4, 1'b0, '0);
        chk("R1 closed window goes to io", n_pio - np, 1);
        chk("R1 closed window data", rd, pio_model(16'hCFC));
        chk("R1 no cfg request", n_cfg, 0);
    endtask

    task automatic t_sel_rw();
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h1234_5678);
        io_xfer(16'hCF8, 3'd4, 1'b0, '0);
        chk("R2 readback closed", rd, 32'h1234_5678);
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h8000_00F0);
        io_xfer(16'hCF8, 3'd4, 1'b0, '0);
        chk("R2 readback bit31", rd, 32'h8000_00F0);
    endtask

    task automatic t_range_pulse();
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h0000_0001);
        chk("R8 pulse on close", {31'd0, chg_seen}, 32'd1);
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h0000_0002);
        chk("R8 no pulse staying closed", {31'd0, chg_seen}, 32'd0);
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h8000_0003);
        chk("R8 pulse on open", {31'd0, chg_seen}, 32'd1);
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h8000_0004);
        chk("R8 no pulse staying open", {31'd0, chg_seen}, 32'd0);
        @(negedge clk);
        chk("R8 pulse lasts one cycle", {31'd0, range_changed}, 32'd0);
    endtask

    task automatic t_closed_window();
        int nc;
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h00AB_5B1C);
        nc = n_cfg;
        io_xfer(16'hCFE, 3'd2, 1'b0, '0);
        chk("R3 port kept", {16'd0, cap_pio_port}, 32'h0000_0CFE);
        chk("R3 size kept", {29'd0, cap_pio_size}, 32'd2);
        chk("R3 read data", rd, pio_model(16'hCFE));
        io_xfer(16'hCFD, 3'd1, 1'b1, 32'h0000_0077);
        chk("R3 write forwarded", {cap_pio_wr, 15'd0, cap_pio_port}, 32'h8000_0CFD);
        chk("R3 wdata kept", cap_pio_wdata, 32'h0000_0077);
        chk("R3 no cfg when closed", n_cfg - nc, 0);
    endtask

    task automatic t_open_window();
        logic [31:0] sv = 32'hFDAB_5B1F;
        logic [31:0] ea;
        int np;
        io_xfer(16'hCF8, 3'd4, 1'b1, sv);
        np = n_pio;
        for (int k = 0; k < 4; k++) begin
            io_xfer(16'hCFC + 16'(k), 3'd1, 1'b0, '0);
            ea = {sv[23:16], sv[15:11], sv[10:8], sv[7:2], 2'(k), 8'h00};
            chk("R4 cfg fields", cap_cfg_addr, ea);
            chk("R4 cfg read data", rd, cfg_model(ea));
        end
        io_xfer(16'hCFC, 3'd4, 1'b1, 32'hCAFE_F00D);
        chk("R4 cfg write kept", {cap_cfg_wr, 28'd0, cap_cfg_size}, 32'h8000_0004);
        chk("R4 cfg wdata kept", cap_cfg_wdata, 32'hCAFE_F00D);
        chk("R4 nothing to io", n_pio - np, 0);
    endtask

    task automatic t_short_sel();
        io_xfer(16'hCF8, 3'd4, 1'b1, 32'h8765_4320);
        io_xfer(16'hCF8, 3'd2, 1'b1, 32'h0000_1111);
        chk("R5 short write forwarded", {cap_pio_wr, 12'd0, cap_pio_size, cap_pio_port},
            {1'b1, 12'd0, 3'd2, 16'hCF8});
        io_xfer(16'hCF8, 3'd4, 1'b0, '0);
        chk("R5 selector unchanged", rd, 32'h8765_4320);
        io_xfer(16'hCF8, 3'd1, 1'b0, '0);
        chk("R5 short read from io", rd, pio_model(16'hCF8));
    endtask

    task automatic t_holes();
        int np;
        int nc;
        np = n_pio;
        nc = n_cfg;
        io_xfer(16'hCF9, 3'd1, 1'b0, '0);
        chk("R6 hole read 0xCF9", rd, 32'hFFFF_FFFF);
        io_xfer(16'hCFB, 3'd4, 1'b0, '0);
        chk("R6 hole read 0xCFB", rd, 32'hFFFF_FFFF);
        io_xfer(16'hCFA, 3'd2, 1'b1, 32'h0000_5555);
        chk("R6 no downstream", (n_pio - np) + (n_cfg - nc), 0);
        io_xfer(16'hCF8, 3'd4, 1'b0, '0);
        chk("R6 selector untouched", rd, 32'h8765_4320);
    endtask

    task automatic t_stall();
        logic [31:0] sv = 32'h8001_0A08;
        logic [31:0] ea;
        io_xfer(16'hCF8, 3'd4, 1'b1, sv);
        stall_cyc    = 4;
        stall_bad    = 1'b0;
        cfg_rsp_sent = 1'b0;
        io_xfer(16'hCFF, 3'd1, 1'b0, '0);
        ea = {sv[23:16], sv[15:11], sv[10:8], sv[7:2], 2'd3, 8'h00};
        chk("R7 request held while stalled", {31'd0, stall_bad}, 32'd0);
        chk("R7 response after cfg response", {31'd0, cfg_rsp_sent}, 32'd1);
        chk("R7 stalled read data", rd, cfg_model(ea));
        stall_cyc = 0;
    endtask

    task automatic t_other_ports();
        io_xfer(16'h0060, 3'd1, 1'b0, '0);
        chk("R9 low port", rd, pio_model(16'h0060));
        io_xfer(16'hFFFF, 3'd1, 1'b0, '0);
        chk("R9 top port", rd, pio_model(16'hFFFF));
        io_xfer(16'hCF4, 3'd4, 1'b0, '0);
        chk("R9 neighbour port", rd, pio_model(16'hCF4));
        io_xfer(16'hD00, 3'd2, 1'b1, 32'h0000_ABCD);
        chk("R9 write forwarded", {cap_pio_wr, 15'd0, cap_pio_port}, 32'h8000_0D00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sel_rw();
        t_range_pulse();
        t_closed_window();
        t_open_window();
        t_short_sel();
        t_holes();
        t_stall();
        t_other_ports();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule